// File: doc/BRIEF.md
# Banked Set/Clear Interrupt Masker

This block collects three banks of 32 level-sensitive interrupt lines and turns them into one interrupt request. Each bank keeps its own enable mask. Software cannot write a mask directly. It can only turn bits on through a set register and turn bits off through a clear register. Because of this, one field can be changed without a read-modify-write sequence.

A 32-bit register port gives read access to three things: each bank's masked pending state, the current masks, and a general-purpose fast-interrupt control word. The interrupt output is the registered OR of every pending source that is enabled.

Addresses are byte offsets. An offset that is not word aligned, or that is not in the map below, is treated as unmapped.

Top module: `banked_irq_masker`

## Requirements
- R1: After reset, every enable bit is 0, the fast-interrupt control word is 0, and `irq_o` and `rdata_o` are 0.
- R2: A read of pending offset 0x00, 0x04 or 0x08 returns the sources of bank 0, 1 or 2 ANDed with that bank's enable mask. The read has no side effect.
- R3: A write to set offset 0x18, 0x10 or 0x14 (banks 0, 1, 2) sets the enable bits of that bank where the data has a 1. It leaves the other bits of that bank unchanged, and it leaves the other banks unchanged.
- R4: A write to clear offset 0x24, 0x1C or 0x20 (banks 0, 1, 2) clears the enable bits of that bank where the data has a 1. Zero bits have no effect, and writing all ones masks the whole bank.
- R5: A read of a bank's set offset or clear offset returns that bank's current enable mask.
- R6: Offset 0x0C holds a 32-bit control word that is written and read back unchanged.
- R7: Reads of offsets outside the map (0x28 to 0x3C, or any offset with a nonzero bit 1 or bit 0) return 0. Writes to those offsets, and writes to the pending offsets, change no state.
- R8: `irq_o` in a cycle equals the OR, over all banks, of sources AND enable as they were in the previous cycle.
- R9: `rdata_o` shows read data in the cycle after a read request (`req_i` high, `we_i` low). In every other cycle it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 3*BANK_W | Interrupt sources; bank b occupies bits [b*BANK_W +: BANK_W] |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | BANK_W | Write data |
| rdata_o | output | BANK_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong enable bit shows up in two places. It changes `irq_o` one cycle after the matching source changes, and it shows in the next read of that bank's pending, set or clear offset. A bank-mapping slip is the subtler fault: a set or clear write lands on the wrong bank, and this appears only when a different bank is read back or its source is raised. The reference model is therefore compared on every cycle under random accesses that cover every offset. This exposes any corruption at the first read or interrupt that depends on the state.

// File: rtl/bsc_irq_pkg.sv
package bsc_irq_pkg;
  localparam int NUM_BANKS = 3;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PEND,
    RK_FIQ,
    RK_SET,
    RK_CLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [1:0]  bank;
  } reg_sel_t;

  // word index -> register; bank order of set/clear groups is fixed: 1, 2, 0
  function automatic reg_sel_t decode_word(input logic [3:0] w);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.bank = 2'd0;
    case (w)
      4'd0: begin s.kind = RK_PEND; s.bank = 2'd0; end
      4'd1: begin s.kind = RK_PEND; s.bank = 2'd1; end
      4'd2: begin s.kind = RK_PEND; s.bank = 2'd2; end
      4'd3: begin s.kind = RK_FIQ;  s.bank = 2'd0; end
      4'd4: begin s.kind = RK_SET;  s.bank = 2'd1; end
      4'd5: begin s.kind = RK_SET;  s.bank = 2'd2; end
      4'd6: begin s.kind = RK_SET;  s.bank = 2'd0; end
      4'd7: begin s.kind = RK_CLR;  s.bank = 2'd1; end
      4'd8: begin s.kind = RK_CLR;  s.bank = 2'd2; end
      4'd9: begin s.kind = RK_CLR;  s.bank = 2'd0; end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bsc_irq_decode.sv
module bsc_irq_decode
  import bsc_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output reg_sel_t             sel_o,
  output logic [NUM_BANKS-1:0] set_o,
  output logic [NUM_BANKS-1:0] clr_o,
  output logic                 fiq_we_o,
  output logic                 rd_o
);
  logic [ADDR_W-1:0] upper;
  logic              mapped;

  assign upper  = addr_i >> 6;
  assign mapped = (addr_i[1:0] == 2'b00) && (upper == '0);

  always_comb begin
    sel_o = mapped ? decode_word(addr_i[5:2]) : '{kind: RK_NONE, bank: 2'd0};
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      set_o[b] = req_i && we_i && (sel_o.kind == RK_SET) && (sel_o.bank == 2'(b));
      clr_o[b] = req_i && we_i && (sel_o.kind == RK_CLR) && (sel_o.bank == 2'(b));
    end
  end

  assign fiq_we_o = req_i && we_i && (sel_o.kind == RK_FIQ);
  assign rd_o     = req_i && !we_i;
endmodule

// File: rtl/bsc_irq_bank.sv
module bsc_irq_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] src_i,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] masked_o
);
  logic [BANK_W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (set_i) begin
      en_q <= en_q | wdata_i;
    end else if (clr_i) begin
      en_q <= en_q & ~wdata_i;
    end
  end

  assign en_o     = en_q;
  assign masked_o = src_i & en_q;
endmodule

// File: rtl/bsc_irq_rdmux.sv
module bsc_irq_rdmux
  import bsc_irq_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  reg_sel_t                        sel_i,
  input  logic [NUM_BANKS*BANK_W-1:0]     masked_i,
  input  logic [NUM_BANKS*BANK_W-1:0]     en_i,
  input  logic [BANK_W-1:0]               fiq_i,
  output logic [BANK_W-1:0]               rdata_o
);
  logic bank_ok;
  assign bank_ok = int'(sel_i.bank) < NUM_BANKS;

  always_comb begin
    rdata_o = '0;
    case (sel_i.kind)
      RK_PEND: if (bank_ok) rdata_o = masked_i[int'(sel_i.bank)*BANK_W +: BANK_W];
      RK_SET,
      RK_CLR:  if (bank_ok) rdata_o = en_i[int'(sel_i.bank)*BANK_W +: BANK_W];
      RK_FIQ:  rdata_o = fiq_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/banked_irq_masker.sv
module banked_irq_masker
  import bsc_irq_pkg::*;
#(
  parameter int BANK_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rdata_o,
  output logic                        irq_o
);
  localparam int FLAT_W = NUM_BANKS * BANK_W;

  reg_sel_t             sel;
  logic [NUM_BANKS-1:0] set_en, clr_en;
  logic                 fiq_we, rd;
  logic [FLAT_W-1:0]    en_flat, masked_flat;
  logic [BANK_W-1:0]    fiq_q, rdata_d, rdata_q;
  logic                 irq_q;

  bsc_irq_decode #(.ADDR_W(ADDR_W)) i_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .sel_o    (sel),
    .set_o    (set_en),
    .clr_o    (clr_en),
    .fiq_we_o (fiq_we),
    .rd_o     (rd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bsc_irq_bank #(.BANK_W(BANK_W)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_en[b]),
      .clr_i    (clr_en[b]),
      .wdata_i  (wdata_i),
      .src_i    (src_i[b*BANK_W +: BANK_W]),
      .en_o     (en_flat[b*BANK_W +: BANK_W]),
      .masked_o (masked_flat[b*BANK_W +: BANK_W])
    );
  end

  bsc_irq_rdmux #(.BANK_W(BANK_W)) i_rdmux (
    .sel_i    (sel),
    .masked_i (masked_flat),
    .en_i     (en_flat),
    .fiq_i    (fiq_q),
    .rdata_o  (rdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (fiq_we) fiq_q <= wdata_i;
      if (rd)     rdata_q <= rdata_d;
      irq_q <= |masked_flat;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/banked_irq_masker_chk.sv
module banked_irq_masker_chk
  import bsc_irq_pkg::*;
#(
  parameter int BANK_W = 32,
  parameter int ADDR_W = 6
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_BANKS*BANK_W-1:0] src_i,
  input logic                        req_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [BANK_W-1:0]           wdata_i,
  input logic [BANK_W-1:0]           rdata_o,
  input logic                        irq_o,
  input logic [NUM_BANKS*BANK_W-1:0] en_flat_i,
  input logic [BANK_W-1:0]           fiq_i
);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(6'h24);
  localparam logic [ADDR_W-1:0] A_FIQ  = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] A_UNM  = ADDR_W'(6'h2C);

  logic wr, rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  // R8
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(src_i & en_flat_i)));

  // R3
  set_bank1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_SET1) |=>
      ((en_flat_i[BANK_W +: BANK_W] & $past(wdata_i)) == $past(wdata_i)));

  // R4
  clr_bank0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CLR0) |=> ((en_flat_i[0 +: BANK_W] & $past(wdata_i)) == '0));

  // R6
  fiq_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_FIQ) |=> (rdata_o == $past(fiq_i)));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_UNM) |=> (rdata_o == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

bind banked_irq_masker banked_irq_masker_chk #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .en_flat_i (en_flat),
  .fiq_i     (fiq_q)
);

// File: tb/test_banked_irq_masker.sv
`timescale 1ns/1ps
module test_banked_irq_masker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  banked_irq_masker i_banked_irq_masker (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [31:0] m_en [3];
  logic [31:0] m_fiq, m_rdata;
  logic        m_irq;
  string       m_tag = "R1";

  function automatic int set_bank(input int a);
    case (a) 'h18: return 0; 'h10: return 1; 'h14: return 2; default: return -1; endcase
  endfunction
  function automatic int clr_bank(input int a);
    case (a) 'h24: return 0; 'h1C: return 1; 'h20: return 2; default: return -1; endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_en[i]) m_en[i] = '0;
      m_fiq = '0; m_rdata = '0; m_irq = 0; m_tag = "R1";
    end else begin
      int a;
      a = int'(addr);
      m_irq = |(src[31:0] & m_en[0]) | |(src[63:32] & m_en[1]) | |(src[95:64] & m_en[2]);
      if (req && !we) begin
        if (a == 0 || a == 4 || a == 8) begin
          m_rdata = src[(a/4)*32 +: 32] & m_en[a/4]; m_tag = "R2";
        end else if (a == 'h0C) begin
          m_rdata = m_fiq; m_tag = "R6";
        end else if (set_bank(a) >= 0) begin
          m_rdata = m_en[set_bank(a)]; m_tag = "R5";
        end else if (clr_bank(a) >= 0) begin
          m_rdata = m_en[clr_bank(a)]; m_tag = "R5";
        end else begin
          m_rdata = '0; m_tag = "R7";
        end
      end else begin
        m_tag = "R9";
      end
      if (req && we) begin
        if (a == 'h0C) m_fiq = wdata;
        else if (set_bank(a) >= 0) m_en[set_bank(a)] = m_en[set_bank(a)] | wdata;
        else if (clr_bank(a) >= 0) m_en[clr_bank(a)] = m_en[clr_bank(a)] & ~wdata;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R8", {31'd0, irq}, {31'd0, m_irq});
      check(m_tag, rdata, m_rdata);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'd0, irq}, 32'd0);
    check("R1", rdata, 32'd0);
    rst_n = 1;
    @(negedge clk);
    rd_chk(6'h18, 32'h0, "R1");
    rd_chk(6'h0C, 32'h0, "R1");
    // set semantics and bank order
    wr(6'h18, 32'h0000_00F0);
    rd_chk(6'h18, 32'h0000_00F0, "R3");
    wr(6'h18, 32'h0000_000F);
    rd_chk(6'h24, 32'h0000_00FF, "R3");
    rd_chk(6'h10, 32'h0, "R3");
    wr(6'h10, 32'h8000_0001);
    rd_chk(6'h1C, 32'h8000_0001, "R5");
    rd_chk(6'h14, 32'h0, "R3");
    // masked pending
    src = {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0F0F};
    @(negedge clk);
    rd_chk(6'h00, 32'h0000_000F, "R2");
    rd_chk(6'h04, 32'h0000_0001, "R2");
    rd_chk(6'h08, 32'h0, "R2");
    check("R8", {31'd0, irq}, 32'd1);
    // clear semantics
    wr(6'h1C, 32'h0000_0001);
    rd_chk(6'h10, 32'h8000_0000, "R4");
    wr(6'h24, 32'hFFFF_FFFF);
    rd_chk(6'h18, 32'h0, "R4");
    @(negedge clk);
    check("R8", {31'd0, irq}, 32'd0);
    // ignored writes, unmapped reads
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h11, 32'hFFFF_FFFF);
    rd_chk(6'h18, 32'h0, "R7");
    rd_chk(6'h10, 32'h8000_0000, "R7");
    rd_chk(6'h28, 32'h0, "R7");
    rd_chk(6'h3C, 32'h0, "R7");
    rd_chk(6'h12, 32'h0, "R7");
    // control word and hold
    wr(6'h0C, 32'hA5A5_1234);
    rd_chk(6'h0C, 32'hA5A5_1234, "R6");
    repeat (3) begin
      @(negedge clk);
      check("R9", rdata, 32'hA5A5_1234);
    end
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      req = ($urandom_range(0, 3) != 0);
      we = $urandom_range(0, 1);
      addr = {$urandom_range(0, 15), 2'b00};
      if ($urandom_range(0, 15) == 0) addr[1:0] = 2'($urandom_range(1, 3));
      wdata = $urandom;
      if ($urandom_range(0, 7) == 0) src = {$urandom, $urandom, $urandom};
      @(negedge clk);
    end
    req = 0; we = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule